// File: doc/BRIEF.md
# Phase-Staggered Multi-Channel PWM Generator

This block drives up to four pulse-width-modulated lines from one clock. Each channel has its own period, its own high time and its own start offset, and keeps its own free-running cycle counter. A shared offset counter begins to count when the block is released. Each channel starts its counter on the cycle in which the offset counter equals that channel's offset. Channels can therefore be placed at fixed phase distances from one another.

The block is released in one of two ways. With sync disabled, release follows a reset or a load strobe by one cycle. With sync enabled, the channels stay quiet until the external sync line falls. That line can come from an unrelated clock, so it passes through a two-flop synchronizer before edge detection. The load strobe captures new settings from the configuration inputs and re-arms the block, so every channel restarts together. Once every channel has started, the offset counter holds its value. It never wraps, so it can never restart a channel that is already running.

Top module: `pwm_stagger_gen`

## Requirements
- R1: A started channel with period P and width W, where 0 < W < P, repeats a pattern of W cycles high followed by P-W cycles low.
- R2: If W >= P the output stays high every cycle once the channel has started. If W = 0 the output stays low.
- R3: A channel whose period is 0 keeps its output low.
- R4: With syncEn low, if loadStb is sampled high on clock edge L, a channel with offset k goes high for the first time right after edge L+2+k. Before that it is low.
- R5: Channels that share the same offset begin their patterns on the same cycle.
- R6: With syncEn high, every output stays low after a load until extSync falls. If extSync is first sampled low on edge A, a channel with offset k goes high for the first time right after edge A+3+k. A high level or a rising edge on extSync releases nothing.
- R7: Period, width and offset inputs take effect only on a cycle with loadStb high. Changing them at any other time leaves the outputs unchanged.
- R8: While rstN is low every output is low. Every channel then holds period 10, width 7 and offset 0. Leaving reset acts as if a load strobe had been sampled on the last edge with rstN low.
- R9: If a load strobe lands on the same edge that a detected sync fall would release the block, the load wins. That fall is discarded and the channels wait for the next one.
- R10: Once the block is released, further extSync falls have no effect. Running channels continue without restart, however long the run lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncEn | input | 1 | High: release waits for a falling edge on extSync |
| extSync | input | 1 | External sync line, may be asynchronous |
| loadStb | input | 1 | One-cycle strobe: capture settings and re-arm |
| periodIn | input | NUM_CH*CNT_W | Per-channel period in cycles, channel n in slice n |
| widthIn | input | NUM_CH*CNT_W | Per-channel high time in cycles |
| offsetIn | input | NUM_CH*CNT_W | Per-channel start offset in cycles |
| pwmOut | output | NUM_CH | PWM outputs, bit n is channel n |

## Verification
A load strobe and a synchronized falling edge of extSync can both act on the same clock edge. The strobe re-arms the block, while the falling edge would release it. The bench times an extSync fall so that the strobe is sampled on exactly the edge where the detected fall would release the block. It then checks that every output stays low through the rest of the wait. Release must come only from a later fall, at A+3+k counted from that later fall. The bench also toggles extSync during long runs, so that falls arrive while channels are running; the waveforms must then continue exactly as the reference model predicts.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;
  // strobes from the control half to the channel datapath
  typedef struct packed {
    logic restart;  // capture settings, clear channel state
    logic run;      // block released, offset counter live
  } ctlStrobe_t;
endpackage

// File: rtl/pwm_stagger_ctl.sv
module pwm_stagger_ctl
  import pwm_stagger_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncEn,
  input  logic             extSync,
  input  logic             loadStb,
  input  logic             allStarted,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] offCnt
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] syncPipe;
  logic              waitQ;
  logic              syncFall;
  logic              release_;

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE_W-2:0], extSync};
  end

  assign syncFall = syncPipe[PIPE_W-1] & ~syncPipe[PIPE_W-2];
  assign release_ = waitQ & (~syncEn | syncFall);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitQ  <= 1'b1;
      offCnt <= '0;
    end else if (loadStb) begin
      waitQ  <= 1'b1;
      offCnt <= '0;
    end else begin
      if (release_) waitQ <= 1'b0;
      if (!waitQ && !allStarted && (offCnt != {CNT_W{1'b1}}))
        offCnt <= offCnt + 1'b1;
    end
  end

  assign ctl.restart = loadStb;
  assign ctl.run     = ~waitQ;

  // R6
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitQ && syncEn && !syncFall && !loadStb) |=> waitQ);

  // R9
  load_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (waitQ && offCnt == '0));

  // R10
  off_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> (offCnt >= $past(offCnt)));
endmodule

// File: rtl/pwm_stagger_chan.sv
module pwm_stagger_chan #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_WIDTH  = 7,
  parameter int DEF_OFFSET = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] offCnt,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] widthIn,
  input  logic [CNT_W-1:0] offsetIn,
  output logic             pwm,
  output logic             started
);
  logic [CNT_W-1:0] perQ, widQ, offQ, cnt;
  logic             atEnd;

  assign atEnd = (perQ == '0) || (cnt >= perQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perQ    <= CNT_W'(DEF_PERIOD);
      widQ    <= CNT_W'(DEF_WIDTH);
      offQ    <= CNT_W'(DEF_OFFSET);
      cnt     <= '0;
      started <= 1'b0;
    end else if (restart) begin
      perQ    <= periodIn;
      widQ    <= widthIn;
      offQ    <= offsetIn;
      cnt     <= '0;
      started <= 1'b0;
    end else if (!started) begin
      cnt <= '0;
      if (run && offCnt == offQ) started <= 1'b1;
    end else begin
      cnt <= atEnd ? '0 : cnt + 1'b1;
    end
  end

  assign pwm = started && (perQ != '0) && (cnt < widQ);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && perQ != '0) |-> (cnt < perQ));

  // R10
  start_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !restart) |=> started);
endmodule

// File: rtl/pwm_stagger_dp.sv
module pwm_stagger_dp
  import pwm_stagger_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_WIDTH  = 7,
  parameter int DEF_OFFSET = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    ctl,
  input  logic [CNT_W-1:0]              offCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  periodIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  widthIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  offsetIn,
  output logic [NUM_CH-1:0]             pwmOut,
  output logic                          allStarted
);
  logic [NUM_CH-1:0] startedVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwm_stagger_chan #(
      .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
      .DEF_WIDTH(DEF_WIDTH), .DEF_OFFSET(DEF_OFFSET)
    ) u_chan (
      .clk(clk), .rstN(rstN),
      .restart(ctl.restart), .run(ctl.run), .offCnt(offCnt),
      .periodIn(periodIn[ch]), .widthIn(widthIn[ch]), .offsetIn(offsetIn[ch]),
      .pwm(pwmOut[ch]), .started(startedVec[ch])
    );
  end

  assign allStarted = &startedVec;

  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |-> (pwmOut == '0));
endmodule

// File: rtl/pwm_stagger_gen.sv
module pwm_stagger_gen
  import pwm_stagger_pkg::*;
#(
  parameter int NUM_CH     = 4,   // 1 to 4
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_WIDTH  = 7,
  parameter int DEF_OFFSET = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          syncEn,
  input  logic                          extSync,
  input  logic                          loadStb,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  periodIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  widthIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  offsetIn,
  output logic [NUM_CH-1:0]             pwmOut
);
  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] offCnt;
  logic             allStarted;

  pwm_stagger_ctl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .extSync(extSync),
    .loadStb(loadStb), .allStarted(allStarted), .ctl(ctl), .offCnt(offCnt)
  );

  pwm_stagger_dp #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
    .DEF_WIDTH(DEF_WIDTH), .DEF_OFFSET(DEF_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .offCnt(offCnt),
    .periodIn(periodIn), .widthIn(widthIn), .offsetIn(offsetIn),
    .pwmOut(pwmOut), .allStarted(allStarted)
  );
endmodule

// File: tb/tb_pwm_stagger_gen.sv
module tb_pwm_stagger_gen;
  localparam int NCH   = 4;
  localparam int CW    = 16;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncEn = 1'b0;
  logic extSync = 1'b0;
  logic loadStb = 1'b0;
  logic [NCH-1:0][CW-1:0] periodIn, widthIn, offsetIn;
  logic [NCH-1:0] pwmOut;

  int cPer[NCH], cWid[NCH], cOff[NCH];
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_stagger_gen #(.NUM_CH(NCH), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .extSync(extSync),
    .loadStb(loadStb), .periodIn(periodIn), .widthIn(widthIn),
    .offsetIn(offsetIn), .pwmOut(pwmOut)
  );

  function automatic bit expLevel(int t, int st, int per, int wid);
    if (per == 0 || t < st) return 1'b0;
    return ((t - st) % per) < wid;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic driveCfg();
    for (int ch = 0; ch < NCH; ch++) begin
      periodIn[ch] = CW'(cPer[ch]);
      widthIn[ch]  = CW'(cWid[ch]);
      offsetIn[ch] = CW'(cOff[ch]);
    end
  endtask

  // ends at the negedge right after the strobe edge (t = 0)
  task automatic doLoad(bit se);
    @(negedge clk);
    syncEn = se;
    driveCfg();
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // compares every channel for cycles 0..n; one check per channel
  task automatic observe(int n, int base, string req, bit wiggle);
    int badT[NCH];
    int badA[NCH];
    foreach (badT[ch]) begin badT[ch] = -1; badA[ch] = 0; end
    for (int t = 0; t <= n; t++) begin
      if (t > 0) begin
        if (wiggle) extSync = ((t / 3) % 2) == 1;
        @(negedge clk);
      end
      for (int ch = 0; ch < NCH; ch++) begin
        if (pwmOut[ch] !== expLevel(t, base + cOff[ch], cPer[ch], cWid[ch]) && badT[ch] < 0) begin
          badT[ch] = t;
          badA[ch] = int'(pwmOut[ch]);
        end
      end
    end
    for (int ch = 0; ch < NCH; ch++) begin
      int e = (badT[ch] < 0) ? 0 : int'(expLevel(badT[ch], base + cOff[ch], cPer[ch], cWid[ch]));
      check(badT[ch] < 0, req, $sformatf("ch%0d level at t=%0d", ch, badT[ch]),
            (badT[ch] < 0) ? 0 : badA[ch], e);
    end
  endtask

  task automatic setCfg(int ch, int p, int w, int o);
    cPer[ch] = p; cWid[ch] = w; cOff[ch] = o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int ch = 0; ch < NCH; ch++) setCfg(ch, 3, 1, 0);
    driveCfg();
    // R8: outputs low in reset, then defaults 10/7/0 apply
    repeat (3) @(negedge clk);
    check(pwmOut == '0, "R8", "pwm during reset", int'(pwmOut), 0);
    for (int ch = 0; ch < NCH; ch++) setCfg(ch, 10, 7, 0);
    rstN = 1'b1;                    // t = 0
    observe(45, 2, "R8", 0);        // also R5: equal offsets start together

    // R4, R1: staggered offsets
    setCfg(0, 8, 3, 0); setCfg(1, 8, 3, 2); setCfg(2, 6, 4, 5); setCfg(3, 9, 2, 11);
    doLoad(0);
    observe(60, 2, "R4", 0);

    // R2, R3: width >= period, width 0, period 0
    setCfg(0, 5, 5, 1); setCfg(1, 4, 9, 0); setCfg(2, 7, 0, 2); setCfg(3, 0, 3, 0);
    doLoad(0);
    observe(40, 2, "R2", 0);
    setCfg(0, 0, 0, 0); setCfg(1, 0, 7, 3); setCfg(2, 1, 1, 0); setCfg(3, 0, 1, 1);
    doLoad(0);
    observe(30, 2, "R3", 0);

    // R5: shared offsets, different periods
    setCfg(0, 6, 2, 4); setCfg(1, 9, 5, 4); setCfg(2, 6, 2, 4); setCfg(3, 3, 1, 0);
    doLoad(0);
    observe(40, 2, "R5", 0);

    // R7: inputs changed without a strobe are ignored
    setCfg(0, 7, 3, 1); setCfg(1, 5, 2, 0); setCfg(2, 11, 6, 3); setCfg(3, 4, 1, 2);
    doLoad(0);
    for (int ch = 0; ch < NCH; ch++) begin
      periodIn[ch] = CW'(2); widthIn[ch] = CW'(1); offsetIn[ch] = CW'(9);
    end
    observe(50, 2, "R7", 0);

    // R6: sync wait, rising edge ignored, release from falling edge
    setCfg(0, 6, 3, 0); setCfg(1, 6, 3, 2); setCfg(2, 10, 5, 7); setCfg(3, 4, 2, 1);
    extSync = 1'b1;
    doLoad(1);
    observe(20, NEVER, "R6", 0);
    extSync = 1'b0;                 // t = 0, first sampled low on edge t=1
    observe(50, 4, "R6", 1);

    // R9: strobe on the edge where the detected fall would release
    extSync = 1'b1;
    doLoad(1);
    observe(6, NEVER, "R9", 0);
    extSync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    observe(15, NEVER, "R9", 0);
    extSync = 1'b1;
    observe(6, NEVER, "R9", 0);
    extSync = 1'b0;
    observe(40, 4, "R9", 0);

    // R10: long run with sync falls arriving while running
    setCfg(0, 5, 2, 0); setCfg(1, 7, 3, 3); setCfg(2, 3, 1, 17); setCfg(3, 9, 4, 40);
    extSync = 1'b1;
    doLoad(1);
    observe(5, NEVER, "R10", 0);
    extSync = 1'b0;
    observe(400, 4, "R10", 1);

    // R1, R4, R6: constrained random rounds
    for (int r = 0; r < 12; r++) begin
      bit se = 1'($urandom_range(0, 1));
      for (int ch = 0; ch < NCH; ch++)
        setCfg(ch, $urandom_range(0, 12), $urandom_range(0, 14), $urandom_range(0, 9));
      if (se) begin
        extSync = 1'b1;
        doLoad(1);
        observe(8, NEVER, "R6", 0);
        extSync = 1'b0;
        observe(60, 4, "R6", 1);
      end else begin
        doLoad(0);
        observe(60, 2, "R1", 0);
      end
    end
    summary();
  end
endmodule